// File: doc/BRIEF.md
# Three-Wire Serial Control Loader with Status Output Selector

This block receives control words over a three-wire serial port: a serial clock, a serial data line and a load strobe. Each rising edge of the serial clock shifts one data bit into a 21-bit shift register, most significant bit first. The two bits shifted in last select one of four holding latches. The other nineteen bits are the payload for that latch. While the load strobe is high, the payload is copied into the selected latch. The copy repeats on every cycle, because the strobe acts on its level and not on an edge. Downstream dividers, phase detectors and charge pumps read their settings from the flat latch output.

The block also drives a shared status pin. Four control bits choose what the pin shows. Two of these bits sit in the first-loop control latch and two in the second-loop control latch. The choices are:
- a constant low;
- either lock indicator, or both ANDed;
- either loop's reference-divider output;
- either loop's main-divider output;
- serial data out for daisy-chaining;
- a counter-reset command, raised on its own output.

In serial-data-out mode, the pin shows the top shift-register bit, captured on each falling edge of the serial clock.

The three serial inputs are sampled in the block's system clock domain through a synchronizer. Edges of the serial clock are detected there. The port keeps working whatever the power-down bits in the latches say.

Top module: `ser_load_port`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), all four latches read zero, so the test bit and both power-down bits are 0. The status pin and the counter-reset output are low.
- R2: Each rising edge of ser_clk shifts ser_dat into bit 0 of the shift register and moves bits up by one. After 21 edges, word bit 20 (first sent) is in S20. The latch index is {S1,S0}, and a latch stores S20..S2 as its payload bits 18..0 (payload bit k is S(k+2)).
- R3: While ser_le is high, the latch selected by the current {S1,S0} copies the payload on every system clock cycle. If the shift register changes while ser_le stays high, the latch follows it.
- R4: While ser_le is low, shifting leaves every latch unchanged.
- R5: The status-pin selection bits sit at S15 (high bit) and S14 (low bit) of latch 2 (first loop) and of latch 0 (second loop). The power-down bit of each loop is S11 of the same latch.
- R6: The selection code is {L2.S15, L2.S14, L0.S15, L0.S14}. It decodes as follows:
  - 0000: low
  - 0100: lock1
  - 0001: lock2
  - 0101: lock1 AND lock2
  - 1x00: ref1_div
  - 0x10: ref2_div
  - 1x01: main1_div
  - 0x11: main2_div
  - 1010: serial data out
  - 1011 and 1110: low (reserved)
- R7: On each falling edge of ser_clk, S20 is captured into the serial-out register. In mode 1010 the status pin shows that register.
- R8: In mode 1111, cnt_rst is high and the status pin is low. In every other mode, cnt_rst is low.
- R9: Shifting and loading work the same when both power-down bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Level-sensitive load strobe |
| lock1 | input | 1 | Lock indicator, first loop |
| lock2 | input | 1 | Lock indicator, second loop |
| ref1_div | input | 1 | Reference divider output, first loop |
| ref2_div | input | 1 | Reference divider output, second loop |
| main1_div | input | 1 | Main divider output, first loop |
| main2_div | input | 1 | Main divider output, second loop |
| stat_out | output | 1 | Multiplexed status pin |
| cnt_rst | output | 1 | Counter-reset command |
| latch_q | output | 76 | Four 19-bit latch payloads, latch i at bits [19*i +: 19] |

## Verification
Two functions can act in the same system cycle: the load of a latch, and the serial-out capture on a falling serial clock. The bench first puts the pin into serial-out mode. It then shifts a word addressed to latch 1, which carries a 1 in S20 where the previous word had a 0. On a single drive step it raises the load strobe and lowers the serial clock, so both synchronized events reach the logic together. The check then requires two things at once: latch 1 holds the new payload, and the pin shows the new top bit. Each result is compared against a bench model of the shift register.

// File: rtl/ser_load_pkg.sv
// Package ser_load_pkg
// Shared constants and the status-selector decode used by the serial loader.
// Assumes the field layout of the control latches is fixed by the port protocol.
package ser_load_pkg;

    // Shift-register bit position of the lowest control bit in a control latch
    localparam int CTL_FIELD_S_LSB = 11;
    // Positions (in shift-register numbering) of the two status-select bits
    localparam int SEL_HI_S = 15;
    localparam int SEL_LO_S = 14;
    // Latch indices that hold loop control words
    localparam int LOOP1_CTL_IDX = 2;
    localparam int LOOP2_CTL_IDX = 0;

    typedef enum logic [3:0] {
        ST_OFF  = 4'd0,
        ST_LD1  = 4'd1,
        ST_LD2  = 4'd2,
        ST_LDB  = 4'd3,
        ST_FC1  = 4'd4,
        ST_FC2  = 4'd5,
        ST_FP1  = 4'd6,
        ST_FP2  = 4'd7,
        ST_SDO  = 4'd8,
        ST_RSV  = 4'd9,
        ST_CRST = 4'd10
    } stat_mode_e;

    // Map the four select bits {a1_hi, a1_lo, a2_hi, a2_lo} onto an output mode
    function automatic stat_mode_e stat_decode(input logic [3:0] sel);
        logic a1_hi, a1_lo, a2_hi, a2_lo;
        stat_mode_e m;
        a1_hi = sel[3];
        a1_lo = sel[2];
        a2_hi = sel[1];
        a2_lo = sel[0];
        if (a1_hi && a2_hi) begin
            unique case ({a1_lo, a2_lo})
                2'b00:   m = ST_SDO;
                2'b11:   m = ST_CRST;
                default: m = ST_RSV;
            endcase
        end else if (a1_hi) begin
            m = a2_lo ? ST_FP1 : ST_FC1;
        end else if (a2_hi) begin
            m = a2_lo ? ST_FP2 : ST_FC2;
        end else begin
            unique case ({a1_lo, a2_lo})
                2'b00:   m = ST_OFF;
                2'b10:   m = ST_LD1;
                2'b01:   m = ST_LD2;
                default: m = ST_LDB;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/ser_sync.sv
// Module ser_sync
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes the inputs change slowly relative to clk (several cycles per level).
module ser_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_in;
                end
            end else begin : g_next
                // Pass the value one stage further
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/ser_shifter.sv
// Module ser_shifter
// Detects serial clock edges in the system domain, shifts data on rising
// edges, and captures the top bit on falling edges for daisy-chain output.
// Assumes sclk_s and sdat_s are already synchronized to clk.
module ser_shifter #(
    parameter int WORD_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdat_s,
    output logic [WORD_W-1:0] shift_q,
    output logic              sdo_q,
    output logic              sclk_rise,
    output logic              sclk_fall
);
    logic sclk_d;

    // Remember the previous serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    // Shift a new bit into the bottom on each rising serial edge
    always_ff @(posedge clk) begin
        if (!rst_n)         shift_q <= '0;
        else if (sclk_rise) shift_q <= {shift_q[WORD_W-2:0], sdat_s};
    end

    // Capture the top bit on each falling serial edge
    always_ff @(posedge clk) begin
        if (!rst_n)         sdo_q <= 1'b0;
        else if (sclk_fall) sdo_q <= shift_q[WORD_W-1];
    end
endmodule

// File: rtl/ser_latch_bank.sv
// Module ser_latch_bank
// A bank of addressed holding registers loaded while the strobe level is high.
// Assumes le_s is synchronized; loads repeat every cycle the strobe is high.
module ser_latch_bank #(
    parameter int NUM_LATCH = 4,
    parameter int PAY_W     = 19,
    parameter int ADDR_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       le_s,
    input  logic [ADDR_W-1:0]          ld_addr,
    input  logic [PAY_W-1:0]           ld_pay,
    output logic [NUM_LATCH*PAY_W-1:0] latch_q
);
    generate
        for (genvar g = 0; g < NUM_LATCH; g++) begin : g_latch
            logic [PAY_W-1:0] val_q;
            logic             hit;

            assign hit = le_s && (ld_addr == ADDR_W'(g));

            // Copy the payload while selected and the strobe is high
            always_ff @(posedge clk) begin
                if (!rst_n)   val_q <= '0;
                else if (hit) val_q <= ld_pay;
            end

            assign latch_q[g*PAY_W +: PAY_W] = val_q;
        end
    endgenerate
endmodule

// File: rtl/ser_stat_sel.sv
// Module ser_stat_sel
// Chooses what the shared status pin shows and raises the counter-reset command.
// Assumes the select bits come straight from the control latches.
module ser_stat_sel
    import ser_load_pkg::*;
(
    input  logic [3:0] sel,
    input  logic       lock1,
    input  logic       lock2,
    input  logic       ref1_div,
    input  logic       ref2_div,
    input  logic       main1_div,
    input  logic       main2_div,
    input  logic       sdo_q,
    output logic       stat_out,
    output logic       cnt_rst
);
    stat_mode_e mode;

    assign mode = stat_decode(sel);

    // Route the chosen source onto the pin
    always_comb begin
        unique case (mode)
            ST_LD1:  stat_out = lock1;
            ST_LD2:  stat_out = lock2;
            ST_LDB:  stat_out = lock1 & lock2;
            ST_FC1:  stat_out = ref1_div;
            ST_FC2:  stat_out = ref2_div;
            ST_FP1:  stat_out = main1_div;
            ST_FP2:  stat_out = main2_div;
            ST_SDO:  stat_out = sdo_q;
            default: stat_out = 1'b0;
        endcase
    end

    assign cnt_rst = (mode == ST_CRST);
endmodule

// File: rtl/ser_load_port.sv
// Module ser_load_port
// Three-wire serial loader: synchronizes the port, shifts words, loads
// addressed latches and drives the multiplexed status pin.
// Assumes serial inputs hold each level for at least STAGES+1 clk cycles.
module ser_load_port
    import ser_load_pkg::*;
#(
    parameter int WORD_W = 21,
    parameter int ADDR_W = 2,
    parameter int STAGES = 2,
    localparam int NUM_LATCH = 1 << ADDR_W,
    localparam int PAY_W     = WORD_W - ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ser_clk,
    input  logic                       ser_dat,
    input  logic                       ser_le,
    input  logic                       lock1,
    input  logic                       lock2,
    input  logic                       ref1_div,
    input  logic                       ref2_div,
    input  logic                       main1_div,
    input  logic                       main2_div,
    output logic                       stat_out,
    output logic                       cnt_rst,
    output logic [NUM_LATCH*PAY_W-1:0] latch_q
);
    localparam int SEL_HI_P = SEL_HI_S - ADDR_W;
    localparam int SEL_LO_P = SEL_LO_S - ADDR_W;

    logic [2:0]          raw_in, sync_out;
    logic                sclk_s, sdat_s, le_s;
    logic [WORD_W-1:0]   shift_q;
    logic                sdo_q, sclk_rise, sclk_fall;
    logic [ADDR_W-1:0]   ld_addr;
    logic [PAY_W-1:0]    ld_pay;
    logic [PAY_W-1:0]    ctl1, ctl2;
    logic [3:0]          stat_sel;

    assign raw_in = {ser_le, ser_dat, ser_clk};
    assign {le_s, sdat_s, sclk_s} = sync_out;

    ser_sync #(.WIDTH(3), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .d_out (sync_out)
    );

    ser_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .sdat_s    (sdat_s),
        .shift_q   (shift_q),
        .sdo_q     (sdo_q),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    assign ld_addr = shift_q[ADDR_W-1:0];
    assign ld_pay  = shift_q[WORD_W-1:ADDR_W];

    ser_latch_bank #(.NUM_LATCH(NUM_LATCH), .PAY_W(PAY_W), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .le_s    (le_s),
        .ld_addr (ld_addr),
        .ld_pay  (ld_pay),
        .latch_q (latch_q)
    );

    assign ctl1     = latch_q[LOOP1_CTL_IDX*PAY_W +: PAY_W];
    assign ctl2     = latch_q[LOOP2_CTL_IDX*PAY_W +: PAY_W];
    assign stat_sel = {ctl1[SEL_HI_P], ctl1[SEL_LO_P], ctl2[SEL_HI_P], ctl2[SEL_LO_P]};

    ser_stat_sel u_stat (
        .sel       (stat_sel),
        .lock1     (lock1),
        .lock2     (lock2),
        .ref1_div  (ref1_div),
        .ref2_div  (ref2_div),
        .main1_div (main1_div),
        .main2_div (main2_div),
        .sdo_q     (sdo_q),
        .stat_out  (stat_out),
        .cnt_rst   (cnt_rst)
    );
endmodule

// File: rtl/ser_load_port_chk.sv
// Module ser_load_port_chk
// Assertion checker for ser_load_port, attached through bind.
// Assumes it observes the synchronized strobe and shifter state of the top.
module ser_load_port_chk #(
    parameter int NUM_LATCH = 4,
    parameter int PAY_W     = 19,
    parameter int ADDR_W    = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       le_s,
    input logic [ADDR_W-1:0]          ld_addr,
    input logic [PAY_W-1:0]           ld_pay,
    input logic [NUM_LATCH*PAY_W-1:0] latch_q,
    input logic                       sclk_fall,
    input logic                       shift_msb,
    input logic                       sdo_q,
    input logic [3:0]                 stat_sel,
    input logic                       stat_out,
    input logic                       cnt_rst
);
    // R3: a cycle with the strobe high leaves the payload in the addressed latch
    a_r3_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
        le_s |=> latch_q[$past(ld_addr)*PAY_W +: PAY_W] == $past(ld_pay));

    // R4: with the strobe low, no latch moves
    a_r4_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !le_s |=> $stable(latch_q));

    // R7: a falling serial edge captures the top shift bit
    a_r7_sdo_capture: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_fall |=> sdo_q == $past(shift_msb));

    // R6: selection code zero keeps the pin low
    a_r6_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_sel == 4'b0000) |-> !stat_out);

    // R8: the reset command only with code 1111 and a low pin
    a_r8_crst_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |-> (!stat_out && stat_sel == 4'b1111));
endmodule

bind ser_load_port ser_load_port_chk #(
    .NUM_LATCH (NUM_LATCH),
    .PAY_W     (PAY_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .le_s      (le_s),
    .ld_addr   (ld_addr),
    .ld_pay    (ld_pay),
    .latch_q   (latch_q),
    .sclk_fall (sclk_fall),
    .shift_msb (shift_q[WORD_W-1]),
    .sdo_q     (sdo_q),
    .stat_sel  (stat_sel),
    .stat_out  (stat_out),
    .cnt_rst   (cnt_rst)
);

// File: tb/ser_load_port_test.sv
module ser_load_port_test;
    localparam int PAY_W = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
    logic lock1 = 0, lock2 = 0, ref1_div = 0, ref2_div = 0, main1_div = 0, main2_div = 0;
    logic stat_out, cnt_rst;
    logic [4*PAY_W-1:0] latch_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [20:0]      sh_model = '0;
    logic             sdo_model = 1'b0;
    logic [PAY_W-1:0] lat_model [4];

    always #4 clk = ~clk;

    ser_load_port uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
        .lock1(lock1), .lock2(lock2), .ref1_div(ref1_div), .ref2_div(ref2_div),
        .main1_div(main1_div), .main2_div(main2_div),
        .stat_out(stat_out), .cnt_rst(cnt_rst), .latch_q(latch_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_latches(input string req);
        for (int i = 0; i < 4; i++)
            chk(req, 32'(latch_q[i*PAY_W +: PAY_W]), 32'(lat_model[i]));
    endtask

    task automatic ser_bit(input logic b);
        ser_dat = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        sh_model = {sh_model[19:0], b};
        if (ser_le) lat_model[sh_model[1:0]] = sh_model[20:2];
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
        sdo_model = sh_model[20];
    endtask

    task automatic ser_word(input logic [20:0] w);
        for (int i = 20; i >= 0; i--) ser_bit(w[i]);
    endtask

    task automatic le_pulse();
        ser_le = 1'b1;
        repeat (4) @(negedge clk);
        lat_model[sh_model[1:0]] = sh_model[20:2];
        ser_le = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [20:0] ctl_word(input logic [4:0] c, input logic [1:0] a);
        return {5'b0, c, 9'b0, a};
    endfunction

    task automatic set_sel(input logic [3:0] s);
        ser_word(ctl_word({s[3], s[2], 3'b0}, 2'b10)); le_pulse();
        ser_word(ctl_word({s[1], s[0], 3'b0}, 2'b00)); le_pulse();
    endtask

    function automatic logic exp_stat(input logic [3:0] s, input logic [5:0] v, input logic sdo);
        // v = {main2, main1, ref2, ref1, lock2, lock1}
        case (s)
            4'b0100:          return v[0];
            4'b0001:          return v[1];
            4'b0101:          return v[0] & v[1];
            4'b1000, 4'b1100: return v[2];
            4'b0010, 4'b0110: return v[3];
            4'b1001, 4'b1101: return v[4];
            4'b0011, 4'b0111: return v[5];
            4'b1010:          return sdo;
            default:          return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [20:0] w;
        for (int i = 0; i < 4; i++) lat_model[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        chk_latches("R1 reset latches");
        chk("R1 reset stat", 32'(stat_out), 0);
        chk("R1 reset cnt_rst", 32'(cnt_rst), 0);

        // R2 / R3: each address with several payloads
        for (int a = 0; a < 4; a++) begin
            for (int p = 0; p < 3; p++) begin
                w = {19'(32'h2A5C3 ^ (a * 32'h1111) ^ (p * 32'h0F0F1)), 2'(a)};
                ser_word(w);
                le_pulse();
                chk_latches("R2 addressed load");
            end
        end

        // R4: shift without strobe leaves latches alone
        ser_word(21'h1F0F03);
        chk_latches("R4 shift with strobe low");
        ser_word(21'h0A5A5A);
        chk_latches("R4 second shift with strobe low");

        // R3: level-sensitive, latch follows while strobe held high
        ser_word({19'h12345, 2'b11});
        ser_le = 1'b1;
        repeat (4) @(negedge clk);
        lat_model[3] = sh_model[20:2];
        chk("R3 latch3 first copy", 32'(latch_q[3*PAY_W +: PAY_W]), 32'(lat_model[3]));
        ser_bit(1'b1);
        chk("R3 latch3 follows shift", 32'(latch_q[3*PAY_W +: PAY_W]), 32'(lat_model[3]));
        ser_le = 1'b0;
        repeat (4) @(negedge clk);
        chk_latches("R3 after held strobe");

        // R5 / R6: exhaustive selector sweep
        for (int s = 0; s < 16; s++) begin
            set_sel(4'(s));
            chk("R5 select bits latch2", 32'(latch_q[2*PAY_W + 13 -: 2]), 32'(s >> 2));
            for (int v = 0; v < 64; v++) begin
                {main2_div, main1_div, ref2_div, ref1_div, lock2, lock1} = 6'(v);
                #1;
                chk("R6 stat decode", 32'(stat_out), 32'(exp_stat(4'(s), 6'(v), sdo_model)));
                chk("R8 cnt_rst", 32'(cnt_rst), 32'(s == 15));
                @(negedge clk);
            end
        end
        {main2_div, main1_div, ref2_div, ref1_div, lock2, lock1} = 6'h3F;

        // R8: counter-reset mode with all sources high
        set_sel(4'b1111);
        #1;
        chk("R8 cnt_rst high", 32'(cnt_rst), 1);
        chk("R8 pin low in reset", 32'(stat_out), 0);
        @(negedge clk);

        // R7: serial data out follows S20 after each falling edge
        set_sel(4'b1010);
        w = 21'h15B3C6;
        for (int i = 20; i >= 0; i--) begin
            ser_bit(w[i]);
            chk("R7 serial out bit", 32'(stat_out), 32'(sh_model[20]));
        end

        // R3 + R7 in one cycle: strobe rise with falling serial edge
        ser_word(21'h0A0A0A);
        w = {1'b1, 18'h2B3C4, 2'b01};
        for (int i = 20; i >= 1; i--) ser_bit(w[i]);
        ser_dat = w[0];
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        sh_model = {sh_model[19:0], w[0]};
        ser_clk = 1'b0;
        ser_le = 1'b1;
        repeat (4) @(negedge clk);
        lat_model[1] = sh_model[20:2];
        sdo_model = sh_model[20];
        chk("R3 load during serial fall", 32'(latch_q[PAY_W +: PAY_W]), 32'(lat_model[1]));
        chk("R7 serial out during load", 32'(stat_out), 32'(sdo_model));
        ser_le = 1'b0;
        repeat (4) @(negedge clk);

        // R9: both loops powered down, port keeps loading
        ser_word(ctl_word(5'b00001, 2'b00)); le_pulse();
        ser_word(ctl_word(5'b00001, 2'b10)); le_pulse();
        ser_word({19'h7654A, 2'b11}); le_pulse();
        ser_word({19'h01234, 2'b01}); le_pulse();
        chk_latches("R9 loads with power-down set");
        chk("R9 pin low in code 0000", 32'(stat_out), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule